// File: doc/BRIEF.md
# Modem Line Auto-Enable Gating

This block sits between two active-low modem control lines (clear-to-send and carrier-detect) and the transmit and receive machinery of a serial channel. It has two jobs. First, it forms the effective transmitter and receiver enables. A mode bit decides whether each line gates its direction in hardware or is only watched. Second, it keeps a status view of both lines and raises an interrupt request when either line changes.

Gating works as follows. With auto-enable off, the software enable bits pass through unchanged. With auto-enable on, clear-to-send gates transmission and carrier-detect gates reception. Local loopback overrides both lines. Auto echo overrides only clear-to-send.

Both pins are resynchronised before use. A change on either synchronised line latches a pending flag. While that flag is pending, the reported line status is held. A clear strobe releases the flag and loads the present line levels.

Top module: `mdm_gate`

## Requirements
- R1: With auto-enable at 0, the transmit enable output equals the software transmit enable bit and the receive enable output equals the software receive enable bit, whatever the line levels.
- R2: With auto-enable at 1 and neither loopback nor echo set, the transmit enable output is 1 only when the software transmit bit is 1 and clear-to-send is asserted. The receive enable output is 1 only when the software receive bit is 1 and carrier-detect is asserted.
- R3: In local loopback with auto-enable at 1, both lines are ignored for enabling: each enable output equals its software bit.
- R4: In auto echo without loopback, with auto-enable at 1, clear-to-send is ignored (the transmit enable equals its software bit), while carrier-detect still gates reception as in R2.
- R5: The pins are active low: a status bit reads 1 when its pin is low. After reset both status bits and the interrupt request are 0, and both enables are 0 while the software bits are 0.
- R6: A pin change reaches the status bits and the pending flag exactly SYNC_STAGES+1 clock edges after the pin changes, and not earlier (3 edges by default).
- R7: A change of either synchronised line sets a pending flag. The interrupt request is the pending flag ANDed with the interrupt enable bit. Lowering the enable masks the request without losing the flag.
- R8: While the flag is pending and no clear is applied, both status bits hold the values captured when the flag was set, even if the lines change again.
- R9: A one-cycle clear strobe drops the pending flag and loads the live synchronised line levels into the status bits on the same edge. If a line change is seen on that same edge, the flag stays set and the status takes the new levels.
- R10: A clear strobe applied with no flag pending leaves the interrupt request at 0 and the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| dcd_n_i | input | 1 | Carrier-detect pin, active low, asynchronous |
| tx_sw_en_i | input | 1 | Software transmit enable bit |
| rx_sw_en_i | input | 1 | Software receive enable bit |
| auto_en_i | input | 1 | Lines act as hardware enables when 1 |
| loop_i | input | 1 | Local loopback mode |
| echo_i | input | 1 | Auto echo mode |
| ext_ie_i | input | 1 | Line-change interrupt enable |
| stat_clr_i | input | 1 | Clear strobe for the pending flag, one cycle |
| tx_en_o | output | 1 | Effective transmit enable |
| rx_en_o | output | 1 | Effective receive enable |
| cts_stat_o | output | 1 | Clear-to-send status, 1 = asserted |
| dcd_stat_o | output | 1 | Carrier-detect status, 1 = asserted |
| irq_o | output | 1 | Line-change interrupt request |

## Verification
The clear strobe and a fresh line change can land on the same clock edge. The bench provokes this by changing the carrier-detect pin, counting the two synchroniser edges, and raising the clear just after the second edge so that both arrive at the third. It then expects the request still high and the status showing the new line level. A further lone clear must then drop the request. The enable paths are swept over every combination of mode bits, software bits and pin levels, against a bench-side decision tree.

// File: rtl/mdm_gate_pkg.sv
`timescale 1ns/1ps
package mdm_gate_pkg;

  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned LINE_CTS  = 0;
  localparam int unsigned LINE_DCD  = 1;

  // Transmit path: the clear-to-send line only matters when auto mode is on
  // and neither echo nor loopback overrides it.
  function automatic logic tx_gate(input logic sw, input logic auto_on,
                                   input logic lpbk, input logic echo,
                                   input logic cts_on);
    return sw & (~auto_on | lpbk | echo | cts_on);
  endfunction

  // Receive path: carrier-detect is overridden by loopback only.
  function automatic logic rx_gate(input logic sw, input logic auto_on,
                                   input logic lpbk, input logic dcd_on);
    return sw & (~auto_on | lpbk | dcd_on);
  endfunction

endpackage

// File: rtl/mdm_line_sync.sv
`timescale 1ns/1ps
module mdm_line_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_n_i,
  output logic [WIDTH-1:0] asrt_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    if (STAGES < 2) begin : g_single
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= ~pin_n_i[g];
      end
      assign asrt_o[g] = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh <= '0;
        else         sh <= {sh[STAGES-2:0], ~pin_n_i[g]};
      end
      assign asrt_o[g] = sh[STAGES-1];
    end
  end

endmodule

// File: rtl/mdm_enable_gate.sv
`timescale 1ns/1ps
module mdm_enable_gate
  import mdm_gate_pkg::*;
(
  input  logic tx_sw_i,
  input  logic rx_sw_i,
  input  logic auto_i,
  input  logic loop_i,
  input  logic echo_i,
  input  logic cts_on_i,
  input  logic dcd_on_i,
  output logic tx_en_o,
  output logic rx_en_o
);

  always_comb begin
    tx_en_o = tx_gate(tx_sw_i, auto_i, loop_i, echo_i, cts_on_i);
    rx_en_o = rx_gate(rx_sw_i, auto_i, loop_i, dcd_on_i);
  end

endmodule

// File: rtl/mdm_status_track.sv
`timescale 1ns/1ps
module mdm_status_track #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] live_i,
  input  logic             clr_i,
  input  logic             ie_i,
  output logic [WIDTH-1:0] stat_o,
  output logic             pend_o,
  output logic             chg_o,
  output logic             irq_o
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] stat_q;
  logic             pend_q;
  logic             load_stat;

  // Named internal events
  assign chg_o     = |(live_i ^ prev_q);
  assign load_stat = ~pend_q | clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= '0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= live_i;
      if (load_stat) stat_q <= live_i;
      if (chg_o)      pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  assign stat_o = stat_q;
  assign pend_o = pend_q;
  assign irq_o  = pend_q & ie_i;

  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |=> pend_q); // R7
  AST_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_i |-> !irq_o); // R7
  AST_STAT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> $stable(stat_q)); // R8
  AST_CLR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !chg_o) |=> !pend_q); // R9
  AST_CLR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !pend_q && !chg_o) |=> (!pend_q && $stable(stat_q))); // R10

endmodule

// File: rtl/mdm_gate.sv
`timescale 1ns/1ps
module mdm_gate
  import mdm_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cts_n_i,
  input  logic dcd_n_i,
  input  logic tx_sw_en_i,
  input  logic rx_sw_en_i,
  input  logic auto_en_i,
  input  logic loop_i,
  input  logic echo_i,
  input  logic ext_ie_i,
  input  logic stat_clr_i,
  output logic tx_en_o,
  output logic rx_en_o,
  output logic cts_stat_o,
  output logic dcd_stat_o,
  output logic irq_o
);

  logic [NUM_LINES-1:0] pin_n;
  logic [NUM_LINES-1:0] line_on;
  logic [NUM_LINES-1:0] stat;
  logic                 pend;
  logic                 line_chg;

  assign pin_n[LINE_CTS] = cts_n_i;
  assign pin_n[LINE_DCD] = dcd_n_i;

  mdm_line_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_n_i (pin_n),
    .asrt_o  (line_on)
  );

  mdm_enable_gate u_gate (
    .tx_sw_i  (tx_sw_en_i),
    .rx_sw_i  (rx_sw_en_i),
    .auto_i   (auto_en_i),
    .loop_i   (loop_i),
    .echo_i   (echo_i),
    .cts_on_i (line_on[LINE_CTS]),
    .dcd_on_i (line_on[LINE_DCD]),
    .tx_en_o  (tx_en_o),
    .rx_en_o  (rx_en_o)
  );

  mdm_status_track #(.WIDTH(NUM_LINES)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .live_i (line_on),
    .clr_i  (stat_clr_i),
    .ie_i   (ext_ie_i),
    .stat_o (stat),
    .pend_o (pend),
    .chg_o  (line_chg),
    .irq_o  (irq_o)
  );

  assign cts_stat_o = stat[LINE_CTS];
  assign dcd_stat_o = stat[LINE_DCD];

  AST_TX_NEEDS_SW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_sw_en_i |-> !tx_en_o); // R1
  AST_MANUAL_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_en_i) |-> (rx_en_o == rx_sw_en_i)); // R1
  AST_LOOP_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_i && rx_sw_en_i) |-> rx_en_o); // R3
  AST_ECHO_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (echo_i && tx_sw_en_i) |-> tx_en_o); // R4
  AST_CHG_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_chg |=> (pend && (irq_o == ext_ie_i))); // R7

endmodule

// File: tb/mdm_gate_tb.sv
`timescale 1ns/1ps
module mdm_gate_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_n = 1'b1, dcd_n = 1'b1;
  logic tx_sw = 1'b0, rx_sw = 1'b0, auto_en = 1'b0, lpbk = 1'b0, echo = 1'b0;
  logic ie = 1'b0, clr = 1'b0;
  logic tx_en, rx_en, cts_st, dcd_st, irq;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mdm_gate #(.SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cts_n_i(cts_n), .dcd_n_i(dcd_n),
    .tx_sw_en_i(tx_sw), .rx_sw_en_i(rx_sw), .auto_en_i(auto_en),
    .loop_i(lpbk), .echo_i(echo), .ext_ie_i(ie), .stat_clr_i(clr),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .cts_stat_o(cts_st),
    .dcd_stat_o(dcd_st), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // Bench-side decision trees for the enables
  function automatic logic exp_tx(logic sw, logic au, logic lb, logic ec, logic pin_n);
    if (!sw) return 1'b0;
    if (!au) return 1'b1;
    if (lb || ec) return 1'b1;
    return (pin_n == 1'b0);
  endfunction

  function automatic logic exp_rx(logic sw, logic au, logic lb, logic pin_n);
    if (!sw) return 1'b0;
    if (!au) return 1'b1;
    if (lb) return 1'b1;
    return (pin_n == 1'b0);
  endfunction

  function automatic string tag_of(logic au, logic lb, logic ec);
    if (!au) return "R1";
    if (lb)  return "R3";
    if (ec)  return "R4";
    return "R2";
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // R5: reset state with idle (high) pins
    chk("R5 reset", {tx_en, rx_en, irq, 1'b0}, 4'h0);
    chk("R5 reset status", {2'b0, dcd_st, cts_st}, 4'h0);

    // Exhaustive enable sweep: pins x mode bits x software bits
    for (int p = 0; p < 4; p++) begin
      cts_n = p[0]; dcd_n = p[1];
      cycles(5);
      for (int m = 0; m < 32; m++) begin
        tx_sw = m[0]; rx_sw = m[1]; auto_en = m[2]; lpbk = m[3]; echo = m[4];
        #1;
        chk(tag_of(auto_en, lpbk, echo),
            {2'b0, tx_en, rx_en},
            {2'b0, exp_tx(tx_sw, auto_en, lpbk, echo, cts_n),
                   exp_rx(rx_sw, auto_en, lpbk, dcd_n)});
        @(negedge clk);
      end
      pulse_clr();
      cycles(1);
      // R5: active-low mapping of status
      chk("R5 polarity", {2'b0, dcd_st, cts_st}, {2'b0, ~dcd_n, ~cts_n});
    end

    // Return to idle and clear
    tx_sw = 0; rx_sw = 0; auto_en = 0; lpbk = 0; echo = 0;
    cts_n = 1'b1; dcd_n = 1'b1;
    cycles(5);
    pulse_clr();
    cycles(1);
    ie = 1'b1;
    #1;
    chk("R10 idle", {3'b0, irq}, 4'h0);

    // R6: latency of a pin change
    @(negedge clk); cts_n = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R6 early", {1'b0, irq, dcd_st, cts_st}, 4'h0);
    @(posedge clk); #1;
    chk("R6 on time", {1'b0, irq, dcd_st, cts_st}, 4'b0101);

    // R8: status frozen while pending
    @(negedge clk); dcd_n = 1'b0;
    cycles(5);
    chk("R8 frozen", {1'b0, irq, dcd_st, cts_st}, 4'b0101);

    // R7: mask keeps the flag
    ie = 1'b0; #1;
    chk("R7 masked", {3'b0, irq}, 4'h0);
    ie = 1'b1; #1;
    chk("R7 unmasked", {3'b0, irq}, 4'h1);

    // R9: clear loads live values
    pulse_clr();
    #1;
    chk("R9 clear", {1'b0, irq, dcd_st, cts_st}, 4'b0011);

    // R10: clear with nothing pending
    pulse_clr();
    #1;
    chk("R10 clear idle", {1'b0, irq, dcd_st, cts_st}, 4'b0011);

    // Set pending via cts going idle
    @(negedge clk); cts_n = 1'b1;
    cycles(5);
    chk("R7 cts change", {1'b0, irq, dcd_st, cts_st}, 4'b0110);

    // R9: clear coinciding with a dcd change
    @(negedge clk); dcd_n = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    clr = 1'b1;
    @(posedge clk); #1;
    clr = 1'b0;
    chk("R9 coincide", {1'b0, irq, dcd_st, cts_st}, 4'b0100);
    cycles(3);
    chk("R9 coincide hold", {1'b0, irq, dcd_st, cts_st}, 4'b0100);
    pulse_clr();
    #1;
    chk("R9 final clear", {1'b0, irq, dcd_st, cts_st}, 4'b0000);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule